// File: doc/BRIEF.md
# Presettable BCD/Binary Down Counter

A presettable synchronous down counter with a width set in 4-bit nibbles and a mode chosen at compile time. In decimal mode each nibble holds one decimal digit. The least significant nibble is the units digit and the next nibble is the tens digit. In binary mode the whole vector is a plain unsigned number. With the default of two nibbles, the counter runs from 99 down to 0 in decimal mode and from 255 down to 0 in binary mode. When it counts past zero it reloads its maximum. Left free-running, it therefore divides the clock by 100 or by 256.

Four active-low controls set how the counter behaves, in strict priority order:
1. Clear forces the maximum count at once.
2. Async load copies the parallel input at once, without a clock edge.
3. Sync load copies the parallel input on the next rising clock edge.
4. Run: when none of the above is active, the active-high inhibit input either holds the count or lets it decrement.

The active-low zero output is low only while the count is zero and inhibit is low. This makes it a carry output. Feeding one stage's zero output into the next stage's inhibit input chains counters on a shared clock, and the later stage decrements once per full cycle of the earlier stage.

Top module: `preset_down_counter`

## Requirements
- R1: While clear_ni is low, count_o equals the maximum (0x99 in decimal mode, 0xFF in binary mode) at once and whatever the other inputs are, including async load. The count stays at the maximum across clock edges until clear_ni rises.
- R2: While clear_ni is high and aload_ni is low, count_o equals load_val_i without waiting for a clock edge. Sync load and inhibit have no effect. After aload_ni rises, counting resumes from the loaded value.
- R3: With clear_ni and aload_ni high and sload_ni low, load_val_i is loaded on the rising clock edge even when inhibit_i is high. Before that edge, count_o does not change.
- R4: With clear_ni, aload_ni and sload_ni all high, a high inhibit_i keeps count_o unchanged across clock edges.
- R5: With the three controls high and inhibit_i low, the count drops by one on each rising edge. In binary mode, 0 goes to 0xFF, so a free-running counter repeats every 256 edges with the zero output low on exactly one of them.
- R6: In decimal mode, bits [3:0] hold the units digit and bits [7:4] hold the tens digit. A units digit of 0 becomes 9 and borrows one from the tens digit (0x30 goes to 0x29). 0x00 goes to 0x99, so a free-running counter repeats every 100 edges with zero_no low on exactly one of them.
- R7: A decimal-mode load with a nibble above 9 is stored as given. Decrementing such a nibble lowers it by one: 0xAF goes to 0xAE, 0xFA goes to 0xF9, and 0xC0 goes to 0xB9.
- R8: zero_no is low exactly when count_o is zero and inhibit_i is low, and it follows those two inputs within the same cycle. A high inhibit_i keeps zero_no high even at zero.
- R9: With two decimal stages on one clock, and the second stage's inhibit_i driven by the first stage's zero_no, the second stage decrements only on the edge where the first stage wraps from 0 to 99.
- R10: A low rst_ni forces the maximum count at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, forces maximum count |
| clear_ni | input | 1 | Clear to maximum, active low, highest priority |
| aload_ni | input | 1 | Asynchronous parallel load, active low |
| sload_ni | input | 1 | Synchronous parallel load, active low |
| inhibit_i | input | 1 | Count inhibit / carry-in, active high |
| load_val_i | input | 4*NIBBLES | Parallel load value |
| count_o | output | 4*NIBBLES | Current count |
| zero_no | output | 1 | Zero detect / carry-out, active low |

## Verification
The clocked properties sample the controls only at rising edges. They therefore assume that any low pulse on clear_ni, aload_ni or rst_ni that starts between edges is still present at the next rising edge. They also assume that load_val_i stays stable while aload_ni is low. The directed stimulus drives controls either at the falling edge or a nanosecond or two after it. It releases asynchronous controls only at a falling edge, after at least one rising edge has passed, and it changes load_val_i only while async load is inactive. The asynchronous paths are checked between edges, before any rising edge could explain the result.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    MODE_CLEAR,
    MODE_ALOAD,
    MODE_SLOAD,
    MODE_HOLD,
    MODE_COUNT
  } pdc_mode_e;
endpackage

// File: rtl/pdc_ctrl_decode.sv
module pdc_ctrl_decode
  import pdc_pkg::*;
(
  input  logic      clear_ni,
  input  logic      aload_ni,
  input  logic      sload_ni,
  input  logic      inhibit_i,
  output pdc_mode_e mode_o
);
  // strict priority: clear > async load > sync load > hold/count
  always_comb begin
    if (!clear_ni)      mode_o = MODE_CLEAR;
    else if (!aload_ni) mode_o = MODE_ALOAD;
    else if (!sload_ni) mode_o = MODE_SLOAD;
    else if (inhibit_i) mode_o = MODE_HOLD;
    else                mode_o = MODE_COUNT;
  end
endmodule

// File: rtl/pdc_bcd_digit.sv
module pdc_bcd_digit (
  input  logic [3:0] dig_i,
  input  logic       borrow_i,
  output logic [3:0] dig_o,
  output logic       borrow_o
);
  always_comb begin
    if (!borrow_i) begin
      dig_o    = dig_i;
      borrow_o = 1'b0;
    end else if (dig_i == 4'd0) begin
      dig_o    = 4'd9;
      borrow_o = 1'b1;
    end else begin
      // invalid nibbles (>9) simply step down
      dig_o    = dig_i - 4'd1;
      borrow_o = 1'b0;
    end
  end
endmodule

// File: rtl/pdc_decrement.sv
module pdc_decrement #(
  parameter int unsigned NIBBLES = 2,
  parameter bit          BCD     = 1'b1,
  localparam int unsigned W      = 4 * NIBBLES
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o,
  output logic         underflow_o
);
  if (BCD) begin : g_bcd
    logic [NIBBLES:0] borrow;
    assign borrow[0] = 1'b1;
    for (genvar g = 0; g < NIBBLES; g++) begin : g_dig
      pdc_bcd_digit u_dig (
        .dig_i   (val_i[4*g +: 4]),
        .borrow_i(borrow[g]),
        .dig_o   (val_o[4*g +: 4]),
        .borrow_o(borrow[g+1])
      );
    end
    assign underflow_o = borrow[NIBBLES];
  end else begin : g_bin
    assign {underflow_o, val_o} = {1'b0, val_i} - {{W{1'b0}}, 1'b1};
  end
endmodule

// File: rtl/pdc_zero_detect.sv
module pdc_zero_detect #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         inhibit_i,
  output logic         zero_no
);
  assign zero_no = ~((val_i == '0) & ~inhibit_i);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
  import pdc_pkg::*;
#(
  parameter int unsigned NIBBLES = 2,
  parameter bit          BCD     = 1'b1,
  localparam int unsigned W      = 4 * NIBBLES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_ni,
  input  logic         aload_ni,
  input  logic         sload_ni,
  input  logic         inhibit_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         zero_no
);
  localparam logic [W-1:0] MAX_CNT = BCD ? {NIBBLES{4'd9}} : {W{1'b1}};

  pdc_mode_e    mode;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_dec;
  logic         underflow;

  pdc_ctrl_decode u_ctrl (
    .clear_ni (clear_ni),
    .aload_ni (aload_ni),
    .sload_ni (sload_ni),
    .inhibit_i(inhibit_i),
    .mode_o   (mode)
  );

  pdc_decrement #(.NIBBLES(NIBBLES), .BCD(BCD)) u_dec (
    .val_i      (cnt_q),
    .val_o      (cnt_dec),
    .underflow_o(underflow)
  );

  // clear and async load act as level overrides on the register
  always_ff @(posedge clk_i or negedge rst_ni or negedge clear_ni or negedge aload_ni) begin
    if (!rst_ni)        cnt_q <= MAX_CNT;
    else if (!clear_ni) cnt_q <= MAX_CNT;
    else if (!aload_ni) cnt_q <= load_val_i;
    else begin
      case (mode)
        MODE_SLOAD: cnt_q <= load_val_i;
        MODE_COUNT: cnt_q <= cnt_dec;
        default:    cnt_q <= cnt_q;
      endcase
    end
  end

  // output follows the overrides between edges
  always_comb begin
    case (mode)
      MODE_CLEAR: count_o = MAX_CNT;
      MODE_ALOAD: count_o = load_val_i;
      default:    count_o = cnt_q;
    endcase
  end

  pdc_zero_detect #(.W(W)) u_zero (
    .val_i    (count_o),
    .inhibit_i(inhibit_i),
    .zero_no  (zero_no)
  );

  AST_CLEAR_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |-> count_o == MAX_CNT) else $error("clear"); // R1
  AST_ALOAD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && !aload_ni) |-> count_o == load_val_i) else $error("aload"); // R2
  AST_SLOAD_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && aload_ni && !sload_ni) |=>
      (!clear_ni || !aload_ni || count_o == $past(load_val_i))) else $error("sload"); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && aload_ni && sload_ni && inhibit_i) |=>
      (!clear_ni || !aload_ni || $stable(count_o))) else $error("hold"); // R4
  AST_WRAP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && aload_ni && sload_ni && !inhibit_i && underflow) |=>
      (!clear_ni || !aload_ni || count_o == MAX_CNT)) else $error("wrap"); // R5
  AST_ZERO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> zero_no) else $error("zero mask"); // R8
endmodule

// File: tb/preset_down_counter_test.sv
`timescale 1ns/1ps
module preset_down_counter_test;
  logic       clk = 1'b0;
  logic       rst_n, clr_n, ald_n, sld_n, inh;
  logic [7:0] ld, ld1;
  logic [7:0] cnt_bcd, cnt_bin, cnt_c1;
  logic       z_bcd, z_bin, z_c1;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  preset_down_counter #(.NIBBLES(2), .BCD(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n), .aload_ni(ald_n),
    .sload_ni(sld_n), .inhibit_i(inh), .load_val_i(ld),
    .count_o(cnt_bcd), .zero_no(z_bcd));

  preset_down_counter #(.NIBBLES(2), .BCD(1'b0)) u_bin (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n), .aload_ni(ald_n),
    .sload_ni(sld_n), .inhibit_i(inh), .load_val_i(ld),
    .count_o(cnt_bin), .zero_no(z_bin));

  // second cascade stage, carry-in from uut
  preset_down_counter #(.NIBBLES(2), .BCD(1'b1)) u_c1 (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n), .aload_ni(ald_n),
    .sload_ni(sld_n), .inhibit_i(z_bcd), .load_val_i(ld1),
    .count_o(cnt_c1), .zero_no(z_c1));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_load(input logic [7:0] v, input logic [7:0] v1);
    ld = v; ld1 = v1; sld_n = 1'b0;
    tick(1);
    sld_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr_n = 1'b1; ald_n = 1'b1; sld_n = 1'b1; inh = 1'b1;
    ld = 8'h00; ld1 = 8'h00;
    #23;
    eq("R10 reset bcd", cnt_bcd, 16'h99);
    eq("R10 reset bin", cnt_bin, 16'hFF);
    eq("R8 zero high after reset", z_bcd, 1'b1);
    tick(1);
    rst_n = 1'b1;
    tick(1);
    eq("R10 after release", cnt_bcd, 16'h99);
  endtask

  task automatic t_sync_load_hold;
    ld = 8'h30; ld1 = 8'h00; sld_n = 1'b0; inh = 1'b1;
    #2;
    eq("R3 no change before edge", cnt_bcd, 16'h99);
    tick(1);
    sld_n = 1'b1;
    eq("R3 loaded while inhibited bcd", cnt_bcd, 16'h30);
    eq("R3 loaded while inhibited bin", cnt_bin, 16'h30);
    tick(3);
    eq("R4 hold bcd", cnt_bcd, 16'h30);
    eq("R4 hold bin", cnt_bin, 16'h30);
  endtask

  task automatic t_count_borrow;
    inh = 1'b0;
    tick(1);
    eq("R6 units borrow 30->29", cnt_bcd, 16'h29);
    eq("R5 binary 30->2F", cnt_bin, 16'h2F);
    inh = 1'b1;
    sync_load(8'h00, 8'h00);
    inh = 1'b0;
    tick(1);
    eq("R6 00->99", cnt_bcd, 16'h99);
    eq("R5 binary 00->FF", cnt_bin, 16'hFF);
  endtask

  task automatic t_bad_nibble;
    inh = 1'b1;
    sync_load(8'hC0, 8'h00);
    eq("R7 invalid nibble stored", cnt_bcd, 16'hC0);
    inh = 1'b0;
    tick(1);
    eq("R7 C0->B9", cnt_bcd, 16'hB9);
    eq("R5 binary C0->BF", cnt_bin, 16'hBF);
    inh = 1'b1;
    sync_load(8'hAF, 8'h00);
    inh = 1'b0;
    tick(1);
    eq("R7 AF->AE", cnt_bcd, 16'hAE);
    inh = 1'b1;
    sync_load(8'hFA, 8'h00);
    inh = 1'b0;
    tick(1);
    eq("R7 FA->F9", cnt_bcd, 16'hF9);
  endtask

  task automatic t_zero_flag;
    inh = 1'b1;
    sync_load(8'h01, 8'h00);
    eq("R8 nonzero keeps flag high", z_bcd, 1'b1);
    inh = 1'b0;
    tick(1);
    eq("R5 count reaches zero", cnt_bcd, 16'h00);
    eq("R8 zero flag low at zero", z_bcd, 1'b0);
    #2 inh = 1'b1;
    #1;
    eq("R8 inhibit masks zero at once", z_bcd, 1'b1);
    tick(2);
    eq("R4 zero held while inhibited", cnt_bcd, 16'h00);
    eq("R8 still masked", z_bcd, 1'b1);
    inh = 1'b0;
    #1;
    eq("R8 unmasked without edge", z_bcd, 1'b0);
    tick(1);
    eq("R6 wrap from zero", cnt_bcd, 16'h99);
  endtask

  task automatic t_divide;
    int zc;
    inh = 1'b1;
    sync_load(8'h99, 8'h00);
    inh = 1'b0;
    zc = 0;
    for (int i = 0; i < 100; i++) begin
      tick(1);
      if (z_bcd === 1'b0) zc++;
    end
    eq("R6 period 100 returns to 99", cnt_bcd, 16'h99);
    eq("R6 one zero per 100", zc[15:0], 16'd1);
    inh = 1'b1;
    sync_load(8'hFF, 8'h00);
    inh = 1'b0;
    zc = 0;
    for (int i = 0; i < 256; i++) begin
      tick(1);
      if (z_bin === 1'b0) zc++;
    end
    eq("R5 period 256 returns to FF", cnt_bin, 16'hFF);
    eq("R5 one zero per 256", zc[15:0], 16'd1);
  endtask

  task automatic t_async_load;
    inh = 1'b0;
    #1 ld = 8'h47; sld_n = 1'b0;
    #1 ald_n = 1'b0;
    #1;
    eq("R2 async load without edge", cnt_bcd, 16'h47);
    eq("R2 async load bin", cnt_bin, 16'h47);
    tick(1);
    eq("R2 overrides count across edge", cnt_bcd, 16'h47);
    ald_n = 1'b1; sld_n = 1'b1;
    tick(1);
    eq("R2 resumes from loaded value", cnt_bcd, 16'h46);
    #1 ld = 8'h00;
    #1 ald_n = 1'b0;
    #1;
    eq("R8 zero follows async load", z_bcd, 1'b0);
    tick(1);
    ald_n = 1'b1;
  endtask

  task automatic t_clear;
    inh = 1'b0;
    #2 ld = 8'h12;
    #1 clr_n = 1'b0; ald_n = 1'b0;
    #1;
    eq("R1 clear beats async load bcd", cnt_bcd, 16'h99);
    eq("R1 clear bin", cnt_bin, 16'hFF);
    tick(2);
    eq("R1 clear holds across edges", cnt_bcd, 16'h99);
    clr_n = 1'b1; ald_n = 1'b1;
    tick(1);
    eq("R1 counts after clear", cnt_bcd, 16'h98);
  endtask

  task automatic t_cascade;
    inh = 1'b0;
    sync_load(8'h02, 8'h05);
    eq("R9 stage0 loaded", cnt_bcd, 16'h02);
    eq("R9 stage1 loaded", cnt_c1, 16'h05);
    tick(2);
    eq("R9 stage1 idle while stage0 runs", cnt_c1, 16'h05);
    eq("R9 carry active at zero", z_bcd, 1'b0);
    tick(1);
    eq("R9 stage0 wraps", cnt_bcd, 16'h99);
    eq("R9 stage1 steps on wrap", cnt_c1, 16'h04);
    tick(100);
    eq("R9 stage1 one step per 100", cnt_c1, 16'h03);
  endtask

  task automatic t_mid_reset;
    inh = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    eq("R10 reset between edges", cnt_bcd, 16'h99);
    tick(1);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sync_load_hold();
    t_count_borrow();
    t_bad_nibble();
    t_zero_flag();
    t_divide();
    t_async_load();
    t_clear();
    t_cascade();
    t_mid_reset();
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule